// File: doc/BRIEF.md
# Presence-Detect Timing Decoder

This block sits beside a memory controller's initialisation logic and turns the first 64 bytes of a module's presence-detect image into timing numbers the controller can load as they are. Bytes arrive one per cycle while a strobe is high, each tagged with its index. The block keeps the bytes it needs, sums bytes 0 to 62, and compares that sum with the value stored at index 63.

Each timing byte uses one of three encodings: whole and tenth nanoseconds packed into two nibbles, quarter nanoseconds, or whole nanoseconds. The block turns each one into picoseconds and then into a count of controller clock cycles, rounding any fraction up. The clock period is set in picoseconds as a parameter, so only integer arithmetic is used. It also passes on the burst-length and CAS-latency bitmaps, together with the largest burst length and the largest whole-cycle latency that each bitmap allows.

Index 0 starts a new image and clears everything captured so far. Indices above 63 belong to data the block does not use and are dropped.

Top module: `spd_timing_parser`

## Requirements
- R1: After reset, `params_valid`, `csum_err`, every cycle output, both masks and both maxima are 0.
- R2: The cycle-time byte (index 9) is read as upper nibble = whole ns and lower nibble = tenths of a ns. `tck_cyc` = ceil((hi*1000 + lo*100) / CLK_PS).
- R3: The bytes at index 27 (precharge), 28 (activate-to-activate) and 29 (RAS-to-CAS) are in quarter-ns units. `trp_cyc`, `trrd_cyc` and `trcd_cyc` = ceil(byte*250 / CLK_PS).
- R4: The bytes at index 30 (active-to-precharge), 41 (row cycle) and 42 (refresh cycle) are in whole ns. `tras_cyc`, `trc_cyc` and `trfc_cyc` = ceil(byte*1000 / CLK_PS).
- R5: `bl_mask` holds the low BL_W bits of the byte at index 16, where bit n means burst length 2^n is supported. `bl_max` is one-hot at the highest set bit, so its value is the largest length, and it is 0 when the mask is 0.
- R6: `cl_mask` holds the low CL_W bits of the byte at index 18, where bit n means latency (n+2)/2 (bit 2 = 2, bit 3 = 2.5, bit 4 = 3). `cl_max_int` is k+1 for the highest set even bit 2k, and 0 when no even bit is set.
- R7: On the cycle after index 63 is accepted, `params_valid` is 1. At the same time, `csum_err` is 1 exactly when the 8-bit wrapping sum of bytes 0 to 62 differs from byte 63.
- R8: A strobed byte with an index above 63 changes no output.
- R9: A strobed byte with index 0 clears every captured field, `params_valid` and `csum_err` by the next cycle, and starts a new checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Byte strobe |
| byte_idx | input | 8 | Index of the byte in the image |
| byte_data | input | 8 | Byte value |
| tck_cyc | output | CYC_W | Cycle time in clocks |
| trp_cyc | output | CYC_W | Row precharge time in clocks |
| trrd_cyc | output | CYC_W | Activate-to-activate delay in clocks |
| trcd_cyc | output | CYC_W | RAS-to-CAS delay in clocks |
| tras_cyc | output | CYC_W | Active-to-precharge time in clocks |
| trc_cyc | output | CYC_W | Row cycle time in clocks |
| trfc_cyc | output | CYC_W | Refresh cycle time in clocks |
| bl_mask | output | BL_W | Supported burst-length bitmap |
| bl_max | output | BL_W | Largest supported burst length |
| cl_mask | output | CL_W | Supported CAS-latency bitmap |
| cl_max_int | output | CLI_W | Largest supported whole-cycle CAS latency |
| params_valid | output | 1 | Image checked, outputs usable |
| csum_err | output | 1 | Stored checksum mismatch |

## Verification
The assertions expect each image to start with a strobed index 0 and to reach index 63 only after bytes 1 to 62. They also expect the index and data to be steady at the sampling edge. The stimulus keeps to this by sending complete images in ascending index order, one byte per cycle. The one exception is a deliberately cut-off image, and that image is always followed by a fresh start at index 0. Bytes above index 63 are sent only after an image is complete, with data chosen so that a stray capture would change a visible output.

// File: rtl/spd_parse_pkg.sv
package spd_parse_pkg;

   localparam int SPD_BYTE_W = 8;
   localparam int SPD_IDX_W  = 8;
   localparam int CSUM_IDX   = 63;
   localparam int BL_IDX     = 16;
   localparam int CL_IDX     = 18;
   localparam int NCONV      = 7;

   localparam int F_TCK  = 0;
   localparam int F_TRP  = 1;
   localparam int F_TRRD = 2;
   localparam int F_TRCD = 3;
   localparam int F_TRAS = 4;
   localparam int F_TRC  = 5;
   localparam int F_TRFC = 6;

   typedef enum logic [1:0] {
      U_NIBBLE = 2'd0,
      U_QTR    = 2'd1,
      U_NS     = 2'd2
   } unit_e;

   function automatic int field_idx(input int k);
      case (k)
         F_TCK:   return 9;
         F_TRP:   return 27;
         F_TRRD:  return 28;
         F_TRCD:  return 29;
         F_TRAS:  return 30;
         F_TRC:   return 41;
         default: return 42;
      endcase
   endfunction

   function automatic unit_e field_unit(input int k);
      case (k)
         F_TCK:                 return U_NIBBLE;
         F_TRP, F_TRRD, F_TRCD: return U_QTR;
         default:               return U_NS;
      endcase
   endfunction

   function automatic int unit_max_ps(input unit_e u);
      case (u)
         U_NIBBLE: return 15 * 1000 + 15 * 100;
         U_QTR:    return 255 * 250;
         default:  return 255 * 1000;
      endcase
   endfunction

endpackage

// File: rtl/spd_field_capture.sv
module spd_field_capture
   import spd_parse_pkg::*;
#(
   parameter int BL_W = 4,
   parameter int CL_W = 7
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                vld_i,
   input  logic [SPD_IDX_W-1:0]                idx_i,
   input  logic [SPD_BYTE_W-1:0]               data_i,
   output logic [NCONV-1:0][SPD_BYTE_W-1:0]    raw_o,
   output logic [BL_W-1:0]                     bl_o,
   output logic [CL_W-1:0]                     cl_o,
   output logic                                valid_o,
   output logic                                err_o
);

   logic [SPD_BYTE_W-1:0] sum_q;
   logic [SPD_BYTE_W-1:0] raw_q [NCONV];
   logic                  in_range;
   logic                  start;

   assign in_range = vld_i && (idx_i <= SPD_IDX_W'(CSUM_IDX));
   assign start    = vld_i && (idx_i == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q   <= '0;
         bl_o    <= '0;
         cl_o    <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else if (in_range) begin
         if (idx_i == '0) begin
            sum_q   <= data_i;
            bl_o    <= '0;
            cl_o    <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
         end else if (idx_i == SPD_IDX_W'(CSUM_IDX)) begin
            valid_o <= 1'b1;
            err_o   <= (sum_q != data_i);
         end else begin
            sum_q <= sum_q + data_i;
            if (idx_i == SPD_IDX_W'(BL_IDX)) bl_o <= data_i[BL_W-1:0];
            if (idx_i == SPD_IDX_W'(CL_IDX)) cl_o <= data_i[CL_W-1:0];
         end
      end
   end

   for (genvar k = 0; k < NCONV; k++) begin : g_field
      localparam int BYTE_AT = field_idx(k);
      always_ff @(posedge clk) begin
         if (!rst_n)
            raw_q[k] <= '0;
         else if (start)
            raw_q[k] <= '0;
         else if (vld_i && idx_i == SPD_IDX_W'(BYTE_AT))
            raw_q[k] <= data_i;
      end
      assign raw_o[k] = raw_q[k];
   end

   // R9: index 0 drops the previous verdict
   a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!valid_o && !err_o && bl_o == '0 && cl_o == '0 && raw_o == '0));

   // R7: a checked image is flagged on the following cycle
   a_r7_valid_after_check: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && idx_i == SPD_IDX_W'(CSUM_IDX)) |=> valid_o);

   a_r7_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> valid_o);

   // R8: bytes past the checksum leave all state alone
   a_r8_high_idx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && idx_i > SPD_IDX_W'(CSUM_IDX)) |=>
         ($stable(raw_o) && $stable(bl_o) && $stable(cl_o) &&
          $stable(valid_o) && $stable(err_o)));

endmodule

// File: rtl/spd_ns_to_cyc.sv
module spd_ns_to_cyc
   import spd_parse_pkg::*;
#(
   parameter unit_e UNIT   = U_NS,
   parameter int    CLK_PS = 5000,
   parameter int    CYC_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SPD_BYTE_W-1:0] raw_i,
   output logic [CYC_W-1:0]      cyc_o
);

   localparam int MAX_CYC = (unit_max_ps(UNIT) + CLK_PS - 1) / CLK_PS;

   if (MAX_CYC >= (1 << CYC_W)) begin : g_bad_width
      $error("CYC_W too narrow for this unit at the chosen clock period");
   end

   logic [31:0] ps;

   if (UNIT == U_NIBBLE) begin : g_nibble
      assign ps = 32'(raw_i[7:4]) * 32'd1000 + 32'(raw_i[3:0]) * 32'd100;
   end else if (UNIT == U_QTR) begin : g_qtr
      assign ps = 32'(raw_i) * 32'd250;
   end else begin : g_ns
      assign ps = 32'(raw_i) * 32'd1000;
   end

   assign cyc_o = CYC_W'((ps + 32'(CLK_PS - 1)) / 32'(CLK_PS));

   // R2, R3, R4: the count covers the time and drops no whole clock
   a_r4_ceil_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cyc_o) * 32'(CLK_PS) >= ps) &&
      ((cyc_o == '0) || ((32'(cyc_o) - 32'd1) * 32'(CLK_PS) < ps)));

endmodule

// File: rtl/spd_lat_decode.sv
module spd_lat_decode #(
   parameter int BL_W  = 4,
   parameter int CL_W  = 7,
   parameter int CLI_W = 3
) (
   input  logic [BL_W-1:0]  bl_mask_i,
   input  logic [CL_W-1:0]  cl_mask_i,
   output logic [BL_W-1:0]  bl_max_o,
   output logic [CLI_W-1:0] cl_int_o
);

   always_comb begin
      bl_max_o = '0;
      for (int n = 0; n < BL_W; n++) begin
         if (bl_mask_i[n]) begin
            bl_max_o    = '0;
            bl_max_o[n] = 1'b1;
         end
      end
   end

   always_comb begin
      cl_int_o = '0;
      for (int k = 0; 2 * k < CL_W; k++) begin
         if (cl_mask_i[2*k]) cl_int_o = CLI_W'(k + 1);
      end
   end

endmodule

// File: rtl/spd_timing_parser.sv
module spd_timing_parser
   import spd_parse_pkg::*;
#(
   parameter int CLK_PS = 5000,
   parameter int CYC_W  = 8,
   parameter int BL_W   = 4,
   parameter int CL_W   = 7,
   localparam int CLI_W = $clog2(CL_W / 2 + 2)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_vld,
   input  logic [SPD_IDX_W-1:0]  byte_idx,
   input  logic [SPD_BYTE_W-1:0] byte_data,
   output logic [CYC_W-1:0]      tck_cyc,
   output logic [CYC_W-1:0]      trp_cyc,
   output logic [CYC_W-1:0]      trrd_cyc,
   output logic [CYC_W-1:0]      trcd_cyc,
   output logic [CYC_W-1:0]      tras_cyc,
   output logic [CYC_W-1:0]      trc_cyc,
   output logic [CYC_W-1:0]      trfc_cyc,
   output logic [BL_W-1:0]       bl_mask,
   output logic [BL_W-1:0]       bl_max,
   output logic [CL_W-1:0]       cl_mask,
   output logic [CLI_W-1:0]      cl_max_int,
   output logic                  params_valid,
   output logic                  csum_err
);

   if (CLK_PS < 1) begin : g_bad_clk
      $error("CLK_PS must be positive");
   end
   if (BL_W < 1 || BL_W > SPD_BYTE_W) begin : g_bad_bl
      $error("BL_W must lie in 1..8");
   end
   if (CL_W < 1 || CL_W > SPD_BYTE_W) begin : g_bad_cl
      $error("CL_W must lie in 1..8");
   end

   logic [NCONV-1:0][SPD_BYTE_W-1:0] raw;
   logic [CYC_W-1:0]                 cyc [NCONV];

   spd_field_capture #(
      .BL_W (BL_W),
      .CL_W (CL_W)
   ) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (byte_vld),
      .idx_i   (byte_idx),
      .data_i  (byte_data),
      .raw_o   (raw),
      .bl_o    (bl_mask),
      .cl_o    (cl_mask),
      .valid_o (params_valid),
      .err_o   (csum_err)
   );

   for (genvar k = 0; k < NCONV; k++) begin : g_conv
      spd_ns_to_cyc #(
         .UNIT   (field_unit(k)),
         .CLK_PS (CLK_PS),
         .CYC_W  (CYC_W)
      ) u_cv (
         .clk   (clk),
         .rst_n (rst_n),
         .raw_i (raw[k]),
         .cyc_o (cyc[k])
      );
   end

   assign tck_cyc  = cyc[F_TCK];
   assign trp_cyc  = cyc[F_TRP];
   assign trrd_cyc = cyc[F_TRRD];
   assign trcd_cyc = cyc[F_TRCD];
   assign tras_cyc = cyc[F_TRAS];
   assign trc_cyc  = cyc[F_TRC];
   assign trfc_cyc = cyc[F_TRFC];

   spd_lat_decode #(
      .BL_W  (BL_W),
      .CL_W  (CL_W),
      .CLI_W (CLI_W)
   ) u_lat (
      .bl_mask_i (bl_mask),
      .cl_mask_i (cl_mask),
      .bl_max_o  (bl_max),
      .cl_int_o  (cl_max_int)
   );

   // R5: largest burst length is a single supported length
   a_r5_bl_max_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bl_max) && ((bl_max & bl_mask) == bl_max) &&
      ((bl_mask == '0) == (bl_max == '0)));

   // R6: reported whole latency is marked in the bitmap
   a_r6_cl_int_supported: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_max_int != '0) |-> cl_mask[2 * (int'(cl_max_int) - 1)]);

   // R1: nothing is flagged straight out of reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!params_valid && !csum_err));

endmodule

// File: tb/spd_timing_parser_tb_top.sv
`timescale 1ns/1ps
module spd_timing_parser_tb_top;

   localparam int CLK_PS = 5000;

   typedef struct {
      int tck, trp, trrd, trcd, tras, trc, trfc;
      int blm, blx, clm, clx, err;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_idx = '0;
   logic [7:0] byte_data = '0;

   logic [7:0] tck_cyc, trp_cyc, trrd_cyc, trcd_cyc, tras_cyc, trc_cyc, trfc_cyc;
   logic [3:0] bl_mask, bl_max;
   logic [6:0] cl_mask;
   logic [2:0] cl_max_int;
   logic       params_valid, csum_err;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];
   exp_t last_exp;
   logic [7:0] img [64];

   always #2.5 clk = ~clk;

   spd_timing_parser #(.CLK_PS(CLK_PS)) dut_i (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_idx(byte_idx),
      .byte_data(byte_data), .tck_cyc(tck_cyc), .trp_cyc(trp_cyc),
      .trrd_cyc(trrd_cyc), .trcd_cyc(trcd_cyc), .tras_cyc(tras_cyc),
      .trc_cyc(trc_cyc), .trfc_cyc(trfc_cyc), .bl_mask(bl_mask),
      .bl_max(bl_max), .cl_mask(cl_mask), .cl_max_int(cl_max_int),
      .params_valid(params_valid), .csum_err(csum_err));

   function automatic int cdiv(input int ps);
      return (ps + CLK_PS - 1) / CLK_PS;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic compare(input exp_t e);
      chk("R7", "params_valid", int'(params_valid), 1);
      chk("R7", "csum_err", int'(csum_err), e.err);
      chk("R2", "tck_cyc", int'(tck_cyc), e.tck);
      chk("R3", "trp_cyc", int'(trp_cyc), e.trp);
      chk("R3", "trrd_cyc", int'(trrd_cyc), e.trrd);
      chk("R3", "trcd_cyc", int'(trcd_cyc), e.trcd);
      chk("R4", "tras_cyc", int'(tras_cyc), e.tras);
      chk("R4", "trc_cyc", int'(trc_cyc), e.trc);
      chk("R4", "trfc_cyc", int'(trfc_cyc), e.trfc);
      chk("R5", "bl_mask", int'(bl_mask), e.blm);
      chk("R5", "bl_max", int'(bl_max), e.blx);
      chk("R6", "cl_mask", int'(cl_mask), e.clm);
      chk("R6", "cl_max_int", int'(cl_max_int), e.clx);
   endtask

   task automatic build(input int seed, input logic [7:0] b9, b16, b18, b27,
                        b28, b29, b30, b41, b42, input bit bad);
      logic [7:0] s = '0;
      for (int i = 0; i < 63; i++) img[i] = 8'((i * 7 + seed * 13) ^ seed);
      img[9] = b9;   img[16] = b16; img[18] = b18;
      img[27] = b27; img[28] = b28; img[29] = b29;
      img[30] = b30; img[41] = b41; img[42] = b42;
      for (int i = 0; i < 63; i++) s = s + img[i];
      img[63] = bad ? (s ^ 8'h5A) : s;
   endtask

   function automatic exp_t expect_img(input bit bad);
      exp_t e;
      int hb;
      e.tck  = cdiv(int'(img[9][7:4]) * 1000 + int'(img[9][3:0]) * 100);
      e.trp  = cdiv(int'(img[27]) * 250);
      e.trrd = cdiv(int'(img[28]) * 250);
      e.trcd = cdiv(int'(img[29]) * 250);
      e.tras = cdiv(int'(img[30]) * 1000);
      e.trc  = cdiv(int'(img[41]) * 1000);
      e.trfc = cdiv(int'(img[42]) * 1000);
      e.blm  = int'(img[16][3:0]);
      e.blx  = 0;
      for (int n = 0; n < 4; n++) if (img[16][n]) e.blx = 1 << n;
      e.clm  = int'(img[18][6:0]);
      e.clx  = 0;
      for (int k = 0; k < 4; k++) if (img[18][2*k]) e.clx = k + 1;
      e.err  = bad ? 1 : 0;
      hb = 0;
      return e;
   endfunction

   task automatic send_bytes(input int count);
      for (int i = 0; i < count; i++) begin
         byte_vld  = 1'b1;
         byte_idx  = 8'(i);
         byte_data = img[i];
         @(negedge clk);
      end
      byte_vld = 1'b0;
   endtask

   task automatic send_img(input bit bad);
      exp_t e = expect_img(bad);
      sb_q.push_back(e);
      last_exp = e;
      send_bytes(64);
      repeat (3) @(negedge clk);
   endtask

   // monitor: one expected item per completed image
   initial begin
      forever begin
         @(posedge params_valid);
         @(negedge clk);
         if (sb_q.size() == 0) begin
            chk("R7", "unexpected completion", 1, 0);
         end else begin
            compare(sb_q.pop_front());
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "params_valid", int'(params_valid), 0);
      chk("R1", "csum_err", int'(csum_err), 0);
      chk("R1", "trc_cyc", int'(trc_cyc), 0);
      chk("R1", "tck_cyc", int'(tck_cyc), 0);
      chk("R1", "bl_max", int'(bl_max), 0);
      chk("R1", "cl_max_int", int'(cl_max_int), 0);

      // image with 3-3-3 style timings
      build(1, 8'h50, 8'h0E, 8'h1C, 8'h3C, 8'h28, 8'h3C, 8'h28, 8'h37, 8'h46, 1'b0);
      send_img(1'b0);
      chk("R4", "trc_cyc literal", int'(trc_cyc), 11);
      chk("R3", "trp_cyc literal", int'(trp_cyc), 3);

      // R8: bytes beyond 63, chosen to disturb any field if captured
      for (int i = 64; i < 100; i++) begin
         byte_vld  = 1'b1;
         byte_idx  = 8'(i);
         byte_data = 8'hFF;
         @(negedge clk);
      end
      byte_idx = 8'd200; byte_data = 8'h00;
      @(negedge clk);
      byte_vld = 1'b0;
      @(negedge clk);
      compare(last_exp);  // R8 unchanged

      // slower timings with round-up
      build(2, 8'h75, 8'h0E, 8'h1C, 8'h48, 8'h28, 8'h48, 8'h28, 8'h3A, 8'h46, 1'b0);
      send_img(1'b0);
      chk("R2", "tck 7.5ns literal", int'(tck_cyc), 2);
      chk("R3", "trcd 18ns literal", int'(trcd_cyc), 4);

      // R7 corrupted checksum
      build(3, 8'h50, 8'h06, 8'h10, 8'h3C, 8'h28, 8'h3C, 8'h28, 8'h37, 8'h46, 1'b1);
      send_img(1'b1);

      // corner values: exact multiples, zero, extremes, no whole latency
      build(4, 8'h0A, 8'h01, 8'h0A, 8'h01, 8'h00, 8'hFF, 8'hFF, 8'h05, 8'h06, 1'b0);
      send_img(1'b0);
      chk("R4", "tras max byte", int'(tras_cyc), 51);
      chk("R6", "no whole latency", int'(cl_max_int), 0);

      // R9 restart mid-image after a valid image
      build(5, 8'h50, 8'h0E, 8'h1C, 8'h3C, 8'h28, 8'h3C, 8'h28, 8'h37, 8'h46, 1'b0);
      byte_vld = 1'b1; byte_idx = 8'd0; byte_data = img[0];
      @(negedge clk);
      byte_vld = 1'b0;
      chk("R9", "params_valid cleared", int'(params_valid), 0);
      chk("R9", "trc_cyc cleared", int'(trc_cyc), 0);
      chk("R9", "cl_mask cleared", int'(cl_mask), 0);
      send_bytes(35);
      chk("R9", "partial image not valid", int'(params_valid), 0);
      send_img(1'b0);

      repeat (4) @(negedge clk);
      chk("R7", "scoreboard drained", sb_q.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule